// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block sits between the store execution path of an out-of-order core and the data cache. A store that executes is written into a free buffer slot together with its address, data and reorder sequence number (its age), and it stays speculative until the core commits or aborts it. Speculative stores never reach the cache. Once committed, a store is written to a single cache write port in program order and its slot is freed. A mispredict flush removes, in one cycle, every speculative store younger than the flush point.

Loads look up the buffer with their address and age in the same cycle. When buffered stores to the same word are older than the load, the youngest of them supplies the data, and that data replaces whatever the cache returned. When no such store exists, the cache data passes through unchanged. Ages are compared modulo 2^GW: age `a` is older than age `b` when the GW-bit difference `a - b` has its top bit set.

Each slot is a small state machine with three states: ENT_FREE (empty), ENT_SPEC (valid and speculative) and ENT_DONE (valid and committed). Its transitions are: alloc (ENT_FREE to ENT_SPEC), commit (ENT_SPEC to ENT_DONE), kill by abort or flush (ENT_SPEC to ENT_FREE), and drain (ENT_DONE to ENT_FREE).

Top module: `spec_store_buf`

## Requirements
- R1: After reset every slot is free: `st_exec_stall` = 0, `cache_wr_valid` = 0 and `ld_hit` = 0.
- R2: A store execute with no stall writes the lowest free slot in state ENT_SPEC. A load sees that store from the next cycle on, not in the cycle the store executes.
- R3: A load hits when a valid store to the same address is strictly older than the load. Among several such stores, the youngest supplies the data. A store with the same age as the load does not match. Age order wraps modulo 2^GW.
- R4: On a hit, `ld_data` returns the buffered data and `ld_hit` = 1. On a miss, `ld_data` equals `ld_cache_data` and `ld_hit` = 0.
- R5: A commit whose age matches a speculative slot moves that slot to ENT_DONE. The slot keeps forwarding to loads until it is drained.
- R6: An abort whose age matches a speculative slot frees it. Loads stop seeing it from the next cycle.
- R7: A flush frees, in one cycle, every speculative slot strictly younger than `flush_age`. Committed slots and slots not younger than `flush_age` are kept.
- R8: `cache_wr_valid` is 1 only when the oldest valid slot is committed, with that slot's address and data on the write port. An older speculative store therefore blocks the drain. When `cache_wr_ready` = 1, one slot drains per cycle and is freed at that clock edge.
- R9: `st_exec_stall` = 1 while all slots are valid. A store execute during a stall is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_exec_valid | input | 1 | Store execute request |
| st_exec_age | input | GW | Age of the executing store |
| st_exec_addr | input | AW | Word address of the store |
| st_exec_data | input | DW | Store data |
| st_exec_stall | output | 1 | No free slot; the execute request is not taken |
| st_commit_valid | input | 1 | Commit notification |
| st_commit_age | input | GW | Age of the committing store |
| st_abort_valid | input | 1 | Abort notification |
| st_abort_age | input | GW | Age of the aborted store |
| flush_valid | input | 1 | Mispredict flush |
| flush_age | input | GW | Flush point; speculative stores younger than this are removed |
| ld_valid | input | 1 | Load lookup request |
| ld_age | input | GW | Age of the load |
| ld_addr | input | AW | Load word address |
| ld_cache_data | input | DW | Data the cache returned for the load |
| ld_hit | output | 1 | Buffer supplies the load data |
| ld_data | output | DW | Load result after the buffer takes priority |
| cache_wr_valid | output | 1 | Committed store presented to the cache |
| cache_wr_addr | output | AW | Cache write address |
| cache_wr_data | output | DW | Cache write data |
| cache_wr_ready | input | 1 | Cache accepts the write this cycle |

## Verification
The forwarding function is driven with a table of loads against four stores of known ages. Three of the stores share one address. The loads are placed between those stores, at the same age as one of them, and at a different address. These cases separate youngest-older selection from oldest-match selection and from an age test that counts equal ages as a match. Directed sequences cover the rest. Commits that arrive out of order show that an older speculative store blocks the drain. A flush at a chosen age removes only the younger speculative stores. A full buffer ignores an extra store. A load issued in the same cycle as a store does not see it, and a store whose age has wrapped past zero still forwards to a later load.

// File: rtl/ssb_pkg.sv
package ssb_pkg;

    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_SPEC = 2'd1,
        ENT_DONE = 2'd2
    } ent_state_e;

endpackage

// File: rtl/ssb_entry.sv
module ssb_entry
    import ssb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int GW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [GW-1:0] wr_age,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          commit_v,
    input  logic [GW-1:0] commit_age,
    input  logic          abort_v,
    input  logic [GW-1:0] abort_age,
    input  logic          flush_v,
    input  logic [GW-1:0] flush_age,
    input  logic          drain,
    output logic          valid,
    output logic          spec,
    output logic [GW-1:0] age,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    ent_state_e    state_q, state_d;
    logic [GW-1:0] age_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          kill;
    logic          hit_commit;

    // a older than b when the modular difference is negative
    function automatic logic older(input logic [GW-1:0] a, input logic [GW-1:0] b);
        logic [GW-1:0] d;
        d = a - b;
        return d[GW-1];
    endfunction

    always_comb begin
        hit_commit = commit_v && (commit_age == age_q);
        kill       = (abort_v && (abort_age == age_q)) ||
                     (flush_v && older(flush_age, age_q));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_FREE: if (alloc)      state_d = ENT_SPEC;
            ENT_SPEC: begin
                if (kill)            state_d = ENT_FREE;
                else if (hit_commit) state_d = ENT_DONE;
            end
            ENT_DONE: if (drain)      state_d = ENT_FREE;
            default:                  state_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (alloc && state_q == ENT_FREE) begin
            age_q  <= wr_age;
            addr_q <= wr_addr;
            data_q <= wr_data;
        end
    end

    always_comb begin
        valid = (state_q != ENT_FREE);
        spec  = (state_q == ENT_SPEC);
        age   = age_q;
        addr  = addr_q;
        data  = data_q;
    end

endmodule

// File: rtl/ssb_select.sv
module ssb_select #(
    parameter int N  = 8,
    parameter int AW = 32,
    parameter int GW = 6,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  valid,
    input  logic [N-1:0]  spec,
    input  logic [GW-1:0] age  [N],
    input  logic [AW-1:0] addr [N],
    input  logic [AW-1:0] ld_addr,
    input  logic [GW-1:0] ld_age,
    output logic          fwd_hit,
    output logic [IW-1:0] fwd_idx,
    output logic          drain_v,
    output logic [IW-1:0] drain_idx
);

    function automatic logic older(input logic [GW-1:0] a, input logic [GW-1:0] b);
        logic [GW-1:0] d;
        d = a - b;
        return d[GW-1];
    endfunction

    logic have_old;

    // oldest valid slot; it drains only when already committed
    always_comb begin
        have_old  = 1'b0;
        drain_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && (!have_old || older(age[i], age[drain_idx]))) begin
                have_old  = 1'b1;
                drain_idx = IW'(i);
            end
        end
        drain_v = have_old && !spec[drain_idx];
    end

    // youngest matching store that is still older than the load
    always_comb begin
        fwd_hit = 1'b0;
        fwd_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (valid[i] && addr[i] == ld_addr && older(age[i], ld_age) &&
                (!fwd_hit || older(age[fwd_idx], age[i]))) begin
                fwd_hit = 1'b1;
                fwd_idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/spec_store_buf.sv
module spec_store_buf
    import ssb_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int GW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_exec_valid,
    input  logic [GW-1:0] st_exec_age,
    input  logic [AW-1:0] st_exec_addr,
    input  logic [DW-1:0] st_exec_data,
    output logic          st_exec_stall,
    input  logic          st_commit_valid,
    input  logic [GW-1:0] st_commit_age,
    input  logic          st_abort_valid,
    input  logic [GW-1:0] st_abort_age,
    input  logic          flush_valid,
    input  logic [GW-1:0] flush_age,
    input  logic          ld_valid,
    input  logic [GW-1:0] ld_age,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_cache_data,
    output logic          ld_hit,
    output logic [DW-1:0] ld_data,
    output logic          cache_wr_valid,
    output logic [AW-1:0] cache_wr_addr,
    output logic [DW-1:0] cache_wr_data,
    input  logic          cache_wr_ready
);

    localparam int IW = $clog2(N);

    logic [N-1:0]  valid_vec;
    logic [N-1:0]  spec_vec;
    logic [GW-1:0] age_q  [N];
    logic [AW-1:0] addr_q [N];
    logic [DW-1:0] data_q [N];

    logic          have_free;
    logic [IW-1:0] free_idx;
    logic          alloc_fire;
    logic          fwd_hit;
    logic [IW-1:0] fwd_idx;
    logic          drain_v;
    logic [IW-1:0] drain_idx;
    logic          drain_fire;

    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                have_free = 1'b1;
                free_idx  = IW'(i);
            end
        end
        st_exec_stall = !have_free;
        alloc_fire    = st_exec_valid && have_free;
    end

    assign drain_fire = drain_v && cache_wr_ready;

    for (genvar g = 0; g < N; g++) begin : g_ent
        ssb_entry #(.AW(AW), .DW(DW), .GW(GW)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc      (alloc_fire && free_idx == IW'(g)),
            .wr_age     (st_exec_age),
            .wr_addr    (st_exec_addr),
            .wr_data    (st_exec_data),
            .commit_v   (st_commit_valid),
            .commit_age (st_commit_age),
            .abort_v    (st_abort_valid),
            .abort_age  (st_abort_age),
            .flush_v    (flush_valid),
            .flush_age  (flush_age),
            .drain      (drain_fire && drain_idx == IW'(g)),
            .valid      (valid_vec[g]),
            .spec       (spec_vec[g]),
            .age        (age_q[g]),
            .addr       (addr_q[g]),
            .data       (data_q[g])
        );
    end

    ssb_select #(.N(N), .AW(AW), .GW(GW)) u_sel (
        .valid     (valid_vec),
        .spec      (spec_vec),
        .age       (age_q),
        .addr      (addr_q),
        .ld_addr   (ld_addr),
        .ld_age    (ld_age),
        .fwd_hit   (fwd_hit),
        .fwd_idx   (fwd_idx),
        .drain_v   (drain_v),
        .drain_idx (drain_idx)
    );

    always_comb begin
        ld_hit         = ld_valid && fwd_hit;
        ld_data        = ld_hit ? data_q[fwd_idx] : ld_cache_data;
        cache_wr_valid = drain_v;
        cache_wr_addr  = addr_q[drain_idx];
        cache_wr_data  = data_q[drain_idx];
    end

endmodule

// File: rtl/spec_store_buf_checker.sv
module spec_store_buf_checker #(
    parameter int N  = 8,
    parameter int GW = 6,
    localparam int IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  valid_vec,
    input logic [N-1:0]  spec_vec,
    input logic [GW-1:0] age_q [N],
    input logic [IW-1:0] drain_idx,
    input logic [IW-1:0] fwd_idx,
    input logic          st_exec_stall,
    input logic          ld_valid,
    input logic          ld_hit,
    input logic [GW-1:0] ld_age,
    input logic          cache_wr_valid,
    input logic          cache_wr_ready
);

    function automatic logic older(input logic [GW-1:0] a, input logic [GW-1:0] b);
        logic [GW-1:0] d;
        d = a - b;
        return d[GW-1];
    endfunction

    // R1: a reset cycle leaves every slot free
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> valid_vec == '0);

    // R3: a forwarded slot is valid and older than the load
    a_r3_fwd_older: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_hit) |-> (valid_vec[fwd_idx] && older(age_q[fwd_idx], ld_age)));

    // R8: the write port never carries a speculative store
    a_r8_drain_committed: assert property (@(posedge clk) disable iff (!rst_n)
        cache_wr_valid |-> (valid_vec[drain_idx] && !spec_vec[drain_idx]));

    // R8: an accepted write frees its slot
    a_r8_drain_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (cache_wr_valid && cache_wr_ready) |=> !valid_vec[$past(drain_idx)]);

    // R9: a stalled cycle allocates nothing
    a_r9_stall_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        st_exec_stall |=> $countones(valid_vec) <= $countones($past(valid_vec)));

endmodule

bind spec_store_buf spec_store_buf_checker #(.N(N), .GW(GW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .valid_vec      (valid_vec),
    .spec_vec       (spec_vec),
    .age_q          (age_q),
    .drain_idx      (drain_idx),
    .fwd_idx        (fwd_idx),
    .st_exec_stall  (st_exec_stall),
    .ld_valid       (ld_valid),
    .ld_hit         (ld_hit),
    .ld_age         (ld_age),
    .cache_wr_valid (cache_wr_valid),
    .cache_wr_ready (cache_wr_ready)
);

// File: tb/spec_store_buf_test.sv
module spec_store_buf_test;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int GW = 6;
    localparam logic [DW-1:0] CDATA = 32'hDEAD_BEEF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_exec_valid = 1'b0;
    logic [GW-1:0] st_exec_age = '0;
    logic [AW-1:0] st_exec_addr = '0;
    logic [DW-1:0] st_exec_data = '0;
    logic          st_exec_stall;
    logic          st_commit_valid = 1'b0;
    logic [GW-1:0] st_commit_age = '0;
    logic          st_abort_valid = 1'b0;
    logic [GW-1:0] st_abort_age = '0;
    logic          flush_valid = 1'b0;
    logic [GW-1:0] flush_age = '0;
    logic          ld_valid = 1'b0;
    logic [GW-1:0] ld_age = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_cache_data = CDATA;
    logic          ld_hit;
    logic [DW-1:0] ld_data;
    logic          cache_wr_valid;
    logic [AW-1:0] cache_wr_addr;
    logic [DW-1:0] cache_wr_data;
    logic          cache_wr_ready = 1'b0;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #10 clk = ~clk;

    spec_store_buf #(.N(8), .AW(AW), .DW(DW), .GW(GW)) uut (.*);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [GW-1:0] age;
        logic          hit;
        logic [DW-1:0] data;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{32'h100, 6'd7,  1'b1, 32'hA2},
        '{32'h100, 6'd12, 1'b1, 32'hA3},
        '{32'h100, 6'd3,  1'b1, 32'hA1},
        '{32'h100, 6'd2,  1'b0, CDATA},
        '{32'h200, 6'd10, 1'b1, 32'hB1},
        '{32'h300, 6'd10, 1'b0, CDATA},
        '{32'h200, 6'd4,  1'b0, CDATA}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_exec(input logic [GW-1:0] a, input logic [AW-1:0] ad, input logic [DW-1:0] d);
        @(negedge clk);
        st_exec_valid = 1'b1; st_exec_age = a; st_exec_addr = ad; st_exec_data = d;
        @(negedge clk);
        st_exec_valid = 1'b0;
    endtask

    task automatic do_commit(input logic [GW-1:0] a);
        @(negedge clk);
        st_commit_valid = 1'b1; st_commit_age = a;
        @(negedge clk);
        st_commit_valid = 1'b0;
    endtask

    task automatic do_abort(input logic [GW-1:0] a);
        @(negedge clk);
        st_abort_valid = 1'b1; st_abort_age = a;
        @(negedge clk);
        st_abort_valid = 1'b0;
    endtask

    task automatic do_load(input string req, input logic [AW-1:0] ad, input logic [GW-1:0] a,
                           input logic eh, input logic [DW-1:0] ed);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = ad; ld_age = a;
        #2;
        chk(req, 32'(ld_hit), 32'(eh));
        chk(req, ld_data, ed);
        ld_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk("R1 stall", 32'(st_exec_stall), 32'd0);
        chk("R1 wr_valid", 32'(cache_wr_valid), 32'd0);
        do_load("R1 no hit", 32'h100, 6'd10, 1'b0, CDATA);

        // R2: stores enter the buffer speculatively
        do_exec(6'd2, 32'h100, 32'hA1);
        do_exec(6'd5, 32'h100, 32'hA2);
        do_exec(6'd9, 32'h100, 32'hA3);
        do_exec(6'd4, 32'h200, 32'hB1);
        #2 chk("R8 spec blocks drain", 32'(cache_wr_valid), 32'd0);

        // R3/R4 vector table
        for (int i = 0; i < 7; i++)
            do_load("R3/R4 table", VECS[i].addr, VECS[i].age, VECS[i].hit, VECS[i].data);

        // R6: abort removes age 9
        do_abort(6'd9);
        do_load("R6 abort", 32'h100, 6'd12, 1'b1, 32'hA2);

        // R5: commit keeps forwarding, drain held by ready
        do_commit(6'd2);
        #2;
        chk("R8 wr_valid", 32'(cache_wr_valid), 32'd1);
        chk("R8 wr_addr", cache_wr_addr, 32'h100);
        chk("R8 wr_data", cache_wr_data, 32'hA1);
        do_load("R5 committed forwards", 32'h100, 6'd3, 1'b1, 32'hA1);
        do_commit(6'd4);
        do_commit(6'd5);

        // R8: program-order drain one per cycle
        @(negedge clk);
        cache_wr_ready = 1'b1;
        #2 chk("R8 drain1", cache_wr_data, 32'hA1);
        @(negedge clk); #2 chk("R8 drain2", cache_wr_data, 32'hB1);
        chk("R8 drain2 addr", cache_wr_addr, 32'h200);
        @(negedge clk); #2 chk("R8 drain3", cache_wr_data, 32'hA2);
        @(negedge clk); #2 chk("R8 empty", 32'(cache_wr_valid), 32'd0);

        // R7/R8: flush and blocking by an older speculative store
        do_exec(6'd20, 32'h400, 32'hD20);
        do_exec(6'd21, 32'h500, 32'hD21);
        do_commit(6'd21);
        #2 chk("R8 older spec blocks", 32'(cache_wr_valid), 32'd0);
        do_exec(6'd22, 32'h400, 32'hD22);
        do_exec(6'd23, 32'h400, 32'hD23);
        @(negedge clk);
        flush_valid = 1'b1; flush_age = 6'd21;
        @(negedge clk);
        flush_valid = 1'b0;
        do_load("R7 flush keeps older", 32'h400, 6'd30, 1'b1, 32'hD20);
        do_abort(6'd20);
        #2;
        chk("R7 committed kept", 32'(cache_wr_valid), 32'd1);
        chk("R7 committed addr", cache_wr_addr, 32'h500);
        @(negedge clk); #2 chk("R8 last drained", 32'(cache_wr_valid), 32'd0);

        // R9: full buffer stalls and ignores a further store
        for (int i = 0; i < 8; i++)
            do_exec(GW'(30 + i), 32'h600 + 32'(i * 4), 32'h6000 + 32'(i));
        #2 chk("R9 stall", 32'(st_exec_stall), 32'd1);
        do_exec(6'd38, 32'h700, 32'h7777);
        do_load("R9 ignored store", 32'h700, 6'd40, 1'b0, CDATA);
        do_abort(6'd30);
        #2 chk("R9 stall released", 32'(st_exec_stall), 32'd0);
        for (int i = 1; i < 8; i++)
            do_abort(GW'(30 + i));

        // R2 timing and R3 wrap of ages
        @(negedge clk);
        st_exec_valid = 1'b1; st_exec_age = 6'd62; st_exec_addr = 32'h800; st_exec_data = 32'hC0DE;
        ld_valid = 1'b1; ld_addr = 32'h800; ld_age = 6'd1;
        #2 chk("R2 not same cycle", 32'(ld_hit), 32'd0);
        @(negedge clk);
        st_exec_valid = 1'b0;
        #2;
        chk("R2 visible next cycle", 32'(ld_hit), 32'd1);
        chk("R3 wrap data", ld_data, 32'hC0DE);
        ld_valid = 1'b0;
        do_load("R3 younger store", 32'h800, 6'd60, 1'b0, CDATA);

        finish_run();
    end

endmodule